// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block takes transmit work from a ring of descriptors that software keeps in host memory. A poll pulse starts a walk, but only when the transmitter and its DMA channel are both enabled. Each descriptor is four 32-bit words at a 16-byte stride from a base address. It names a buffer and a segment length, and it carries marks for the first and last segment of a frame.

The walker reads each owned descriptor through a word-wide request/acknowledge memory port. It copies the segment bytes into a local frame store. When the last segment is in, it plays the assembled frame out on a byte stream with valid/ready handshaking. The frame goes to the line port, or to a loopback port when loopback is selected. After each descriptor the walker writes word 0 back with the ownership bit cleared. It pulses the status outputs that the descriptor asked for, then moves on to the next slot. The walk ends at the first descriptor that software still owns.

Top module: `txring_fetch`

## Requirements
- R1: After reset the block makes no memory request, drives no stream valid, and `busy` is 0.
- R2: A walk starts only on a `poll_req` pulse while `ctl_tx_en` and `ctl_dma_en` are both 1. A poll while either one is 0 is dropped and is not remembered.
- R3: Descriptor slot i sits at byte address `ring_base + 16*i`. Word 0 bit 31 is ownership (1 = hardware). Word 1 bits 10:0 give the segment length in bytes. Word 2 is the buffer byte address, whose low two bits are ignored. Buffer bytes are taken little-endian within each word.
- R4: A descriptor whose ownership bit is 0 ends the walk. It gives a one-cycle `st_no_buf` pulse and is not written back.
- R5: Word 1 bit 28 (first segment) empties the frame store before that segment's bytes are added. Segments are appended in ring order. On word 1 bit 27 (last segment) the frame is sent, with `tlast` on its final byte only.
- R6: While `ctl_loop_en` is 1 when a frame starts, that frame goes out on the loopback port and the line port stays idle.
- R7: After its data is handled, and after its frame is sent if it is a last segment, each owned descriptor's word 0 is written back with bit 31 cleared and every other bit unchanged.
- R8: At that write-back, word 1 bit 29 gives a one-cycle `st_tx_ok` pulse and word 1 bit 30 gives a one-cycle `st_tx_done` pulse.
- R9: Word 1 bit 31 (end of ring) sends the walk back to slot 0. Otherwise the slot index goes up by one. The index is kept from one walk to the next.
- R10: Frame bytes past `FRAME_MAX` are dropped, and a one-cycle `st_trunc` pulse follows the send of that frame.
- R11: A poll that arrives during a walk is held, and one more walk starts after the current one ends.
- R12: While a stream valid is high and ready is low, the data and last mark hold steady.
- R13: One poll processes owned descriptors one after another until an unowned one is met.
- R14: A segment of length 0 adds no bytes. A last-segment descriptor on an empty frame sends nothing but is still written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_tx_en | input | 1 | Transmitter enable |
| ctl_dma_en | input | 1 | Transmit DMA enable |
| ctl_loop_en | input | 1 | Route frames to the loopback port |
| poll_req | input | 1 | One-cycle poll-demand pulse |
| ring_base | input | AW | Byte address of descriptor slot 0 |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_tdata | output | 8 | Line stream byte |
| tx_tvalid | output | 1 | Line stream valid |
| tx_tlast | output | 1 | Final byte of frame on line stream |
| tx_tready | input | 1 | Line stream ready |
| lb_tdata | output | 8 | Loopback stream byte |
| lb_tvalid | output | 1 | Loopback stream valid |
| lb_tlast | output | 1 | Final byte of frame on loopback stream |
| lb_tready | input | 1 | Loopback stream ready |
| st_no_buf | output | 1 | Pulse: walk stopped at an unowned descriptor |
| st_tx_ok | output | 1 | Pulse: transmit-ok status requested |
| st_tx_done | output | 1 | Pulse: transmit-finished status requested |
| st_trunc | output | 1 | Pulse: last frame was truncated |
| busy | output | 1 | A walk is in progress |

## Verification
The bench sweeps single-segment frames of every length from 1 to 12. A design that picked the wrong byte lane, or slipped by one at a word edge, would corrupt or drop the tail bytes. Multi-segment frames with lengths that are not word multiples, a repeated first-segment mark, and a 40-byte frame against a 32-byte store test the reset, append and truncation rules. A design that got these wrong would leak stale bytes, lose a segment, or overrun the store. End-of-ring wrap, index carry-over between polls, a second poll during a walk, a zero-length frame and loopback routing are also covered. A design that got any of these wrong would read the wrong slot, miss the extra pass, stream an empty frame, or send the frame on the wrong port. The ready inputs are throttled throughout, so a design that advanced without a handshake would lose bytes.

// File: rtl/txring_pkg.sv
package txring_pkg;

  // descriptor field positions shared with software
  localparam int OWN_BIT    = 31;
  localparam int SEG_LEN_W  = 11;
  localparam int LAST_BIT   = 27;
  localparam int FIRST_BIT  = 28;
  localparam int OKREQ_BIT  = 29;
  localparam int FINREQ_BIT = 30;
  localparam int EOR_BIT    = 31;
  localparam int SLOT_LG2   = 4;

  typedef enum logic [2:0] {
    W_IDLE, W_D0, W_D1, W_D2, W_DRD, W_DWR, W_SEND, W_WB
  } walk_st_t;

  typedef enum logic [1:0] {
    E_IDLE, E_RD, E_LD, E_WT
  } emit_st_t;

endpackage

// File: rtl/txring_frame_ram.sv
module txring_frame_ram #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end

endmodule

// File: rtl/txring_emit.sv
module txring_emit
  import txring_pkg::*;
#(
  parameter int FRAME_MAX = 2048,
  localparam int FA_W = $clog2(FRAME_MAX),
  localparam int FL_W = FA_W + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [FL_W-1:0] frame_len,
  input  logic            route_lb,
  output logic [FA_W-1:0] rd_addr,
  input  logic [7:0]      rd_data,
  output logic [7:0]      out_data,
  output logic            out_last,
  output logic            vld_line,
  output logic            vld_lb,
  input  logic            rdy_line,
  input  logic            rdy_lb,
  output logic            done
);

  emit_st_t        st;
  logic [FL_W-1:0] ptr;
  logic [FL_W-1:0] len_r;
  logic            lb_r;
  logic            vld;
  logic            rdy_sel;

  assign rd_addr  = ptr[FA_W-1:0];
  assign rdy_sel  = lb_r ? rdy_lb : rdy_line;
  assign vld_line = vld & ~lb_r;
  assign vld_lb   = vld & lb_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= E_IDLE;
      ptr      <= '0;
      len_r    <= '0;
      lb_r     <= 1'b0;
      vld      <= 1'b0;
      out_data <= '0;
      out_last <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        E_IDLE: if (start) begin
          ptr   <= '0;
          len_r <= frame_len;
          lb_r  <= route_lb;
          if (frame_len == '0) done <= 1'b1;
          else                 st   <= E_RD;
        end
        E_RD: st <= E_LD;
        E_LD: begin
          out_data <= rd_data;
          out_last <= (ptr == len_r - 1'b1);
          vld      <= 1'b1;
          ptr      <= ptr + 1'b1;
          st       <= E_WT;
        end
        E_WT: if (rdy_sel) begin
          vld <= 1'b0;
          if (out_last) begin
            done <= 1'b1;
            st   <= E_IDLE;
          end else begin
            st <= E_RD;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/txring_walker.sv
module txring_walker
  import txring_pkg::*;
#(
  parameter int AW        = 32,
  parameter int IDX_W     = 8,
  parameter int FRAME_MAX = 2048,
  localparam int FA_W = $clog2(FRAME_MAX),
  localparam int FL_W = FA_W + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctl_tx_en,
  input  logic            ctl_dma_en,
  input  logic            poll_req,
  input  logic [AW-1:0]   ring_base,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata,
  output logic            ram_we,
  output logic [FA_W-1:0] ram_waddr,
  output logic [7:0]      ram_wdata,
  output logic            emit_start,
  output logic [FL_W-1:0] frame_len,
  input  logic            emit_done,
  output logic            st_no_buf,
  output logic            st_tx_ok,
  output logic            st_tx_done,
  output logic            st_trunc,
  output logic            busy
);

  walk_st_t             state;
  logic [IDX_W-1:0]     idx;
  logic [31:0]          w0, w1, wdat;
  logic [AW-1:0]        buf_ptr;
  logic [SEG_LEN_W-1:0] seg_left;
  logic [1:0]           lane;
  logic                 trunc;
  logic                 pend;
  logic [AW-1:0]        slot_addr;
  logic                 room;
  logic                 ack_now;

  assign slot_addr = ring_base + (AW'(idx) << SLOT_LG2);
  assign room      = frame_len < FL_W'(FRAME_MAX);
  assign ack_now   = mem_req & mem_ack;
  assign busy      = (state != W_IDLE);
  assign ram_we    = (state == W_DWR) & room;
  assign ram_waddr = frame_len[FA_W-1:0];
  assign ram_wdata = wdat[{lane, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= W_IDLE;
      idx        <= '0;
      w0         <= '0;
      w1         <= '0;
      wdat       <= '0;
      buf_ptr    <= '0;
      seg_left   <= '0;
      lane       <= '0;
      trunc      <= 1'b0;
      pend       <= 1'b0;
      frame_len  <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      emit_start <= 1'b0;
      st_no_buf  <= 1'b0;
      st_tx_ok   <= 1'b0;
      st_tx_done <= 1'b0;
      st_trunc   <= 1'b0;
    end else begin
      emit_start <= 1'b0;
      st_no_buf  <= 1'b0;
      st_tx_ok   <= 1'b0;
      st_tx_done <= 1'b0;
      st_trunc   <= 1'b0;
      if (poll_req && state != W_IDLE) pend <= 1'b1;

      case (state)
        W_IDLE: if ((pend || poll_req) && ctl_tx_en && ctl_dma_en) begin
          pend  <= 1'b0;
          state <= W_D0;
        end

        W_D0: if (!mem_req) begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= slot_addr;
        end else if (ack_now) begin
          mem_req <= 1'b0;
          w0      <= mem_rdata;
          if (!mem_rdata[OWN_BIT]) begin
            st_no_buf <= 1'b1;
            state     <= W_IDLE;
          end else begin
            state <= W_D1;
          end
        end

        W_D1: if (!mem_req) begin
          mem_req  <= 1'b1;
          mem_addr <= slot_addr + AW'(4);
        end else if (ack_now) begin
          mem_req  <= 1'b0;
          w1       <= mem_rdata;
          seg_left <= mem_rdata[SEG_LEN_W-1:0];
          if (mem_rdata[FIRST_BIT]) begin
            frame_len <= '0;
            trunc     <= 1'b0;
          end
          state <= W_D2;
        end

        W_D2: if (!mem_req) begin
          mem_req  <= 1'b1;
          mem_addr <= slot_addr + AW'(8);
        end else if (ack_now) begin
          mem_req <= 1'b0;
          buf_ptr <= {mem_rdata[AW-1:2], 2'b00};
          if (seg_left != '0) begin
            state <= W_DRD;
          end else if (w1[LAST_BIT]) begin
            emit_start <= 1'b1;
            state      <= W_SEND;
          end else begin
            state <= W_WB;
          end
        end

        W_DRD: if (!mem_req) begin
          mem_req  <= 1'b1;
          mem_addr <= buf_ptr;
        end else if (ack_now) begin
          mem_req <= 1'b0;
          wdat    <= mem_rdata;
          lane    <= 2'd0;
          state   <= W_DWR;
        end

        W_DWR: begin
          if (room) frame_len <= frame_len + 1'b1;
          else      trunc     <= 1'b1;
          seg_left <= seg_left - 1'b1;
          lane     <= lane + 1'b1;
          if (seg_left == SEG_LEN_W'(1)) begin
            if (w1[LAST_BIT]) begin
              emit_start <= 1'b1;
              state      <= W_SEND;
            end else begin
              state <= W_WB;
            end
          end else if (lane == 2'd3) begin
            buf_ptr <= buf_ptr + AW'(4);
            state   <= W_DRD;
          end
        end

        W_SEND: if (emit_done) begin
          st_trunc <= trunc;
          state    <= W_WB;
        end

        W_WB: if (!mem_req) begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= slot_addr;
          mem_wdata <= w0 & ~(32'd1 << OWN_BIT);
        end else if (ack_now) begin
          mem_req    <= 1'b0;
          mem_we     <= 1'b0;
          st_tx_ok   <= w1[OKREQ_BIT];
          st_tx_done <= w1[FINREQ_BIT];
          idx        <= w1[EOR_BIT] ? '0 : idx + 1'b1;
          state      <= W_D0;
        end

        default: state <= W_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/txring_fetch.sv
module txring_fetch #(
  parameter int AW        = 32,
  parameter int IDX_W     = 8,
  parameter int FRAME_MAX = 2048
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_tx_en,
  input  logic          ctl_dma_en,
  input  logic          ctl_loop_en,
  input  logic          poll_req,
  input  logic [AW-1:0] ring_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic [7:0]    tx_tdata,
  output logic          tx_tvalid,
  output logic          tx_tlast,
  input  logic          tx_tready,
  output logic [7:0]    lb_tdata,
  output logic          lb_tvalid,
  output logic          lb_tlast,
  input  logic          lb_tready,
  output logic          st_no_buf,
  output logic          st_tx_ok,
  output logic          st_tx_done,
  output logic          st_trunc,
  output logic          busy
);

  localparam int FA_W = $clog2(FRAME_MAX);
  localparam int FL_W = FA_W + 1;

  logic            ram_we;
  logic [FA_W-1:0] ram_waddr, ram_raddr;
  logic [7:0]      ram_wdata, ram_rdata;
  logic            emit_start, emit_done;
  logic [FL_W-1:0] frame_len;
  logic [7:0]      out_data;
  logic            out_last;

  txring_walker #(.AW(AW), .IDX_W(IDX_W), .FRAME_MAX(FRAME_MAX)) u_walk (
    .clk(clk), .rst(rst),
    .ctl_tx_en(ctl_tx_en), .ctl_dma_en(ctl_dma_en), .poll_req(poll_req),
    .ring_base(ring_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .emit_start(emit_start), .frame_len(frame_len), .emit_done(emit_done),
    .st_no_buf(st_no_buf), .st_tx_ok(st_tx_ok), .st_tx_done(st_tx_done),
    .st_trunc(st_trunc), .busy(busy)
  );

  txring_frame_ram #(.DEPTH(FRAME_MAX)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  txring_emit #(.FRAME_MAX(FRAME_MAX)) u_emit (
    .clk(clk), .rst(rst), .start(emit_start), .frame_len(frame_len),
    .route_lb(ctl_loop_en), .rd_addr(ram_raddr), .rd_data(ram_rdata),
    .out_data(out_data), .out_last(out_last),
    .vld_line(tx_tvalid), .vld_lb(lb_tvalid),
    .rdy_line(tx_tready), .rdy_lb(lb_tready), .done(emit_done)
  );

  assign tx_tdata = out_data;
  assign lb_tdata = out_data;
  assign tx_tlast = out_last;
  assign lb_tlast = out_last;

endmodule

// File: rtl/txring_fetch_chk.sv
module txring_fetch_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [7:0]    tx_tdata,
  input logic          tx_tvalid,
  input logic          tx_tlast,
  input logic          tx_tready,
  input logic [7:0]    lb_tdata,
  input logic          lb_tvalid,
  input logic          lb_tready,
  input logic          st_no_buf
);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R7
  wb_clears_own_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> !mem_wdata[31]);

  // R12
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_tvalid && !tx_tready |=> tx_tvalid && $stable(tx_tdata) && $stable(tx_tlast));

  // R12
  lb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    lb_tvalid && !lb_tready |=> lb_tvalid && $stable(lb_tdata));

  // R6
  one_port_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_tvalid && lb_tvalid));

  // R4
  nobuf_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    st_no_buf |=> !st_no_buf);

endmodule

bind txring_fetch txring_fetch_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .tx_tdata(tx_tdata), .tx_tvalid(tx_tvalid), .tx_tlast(tx_tlast),
  .tx_tready(tx_tready), .lb_tdata(lb_tdata), .lb_tvalid(lb_tvalid),
  .lb_tready(lb_tready), .st_no_buf(st_no_buf)
);

// File: tb/test_txring_fetch.sv
module test_txring_fetch;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int FMAX = 32;
  localparam int BUF_BASE = 'h400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_tx_en = 1'b0, ctl_dma_en = 1'b0, ctl_loop_en = 1'b0, poll_req = 1'b0;
  logic [AW-1:0] ring_base = '0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic [7:0] tx_tdata, lb_tdata;
  logic tx_tvalid, tx_tlast, lb_tvalid, lb_tlast, tx_tready = 1'b0, lb_tready = 1'b0;
  logic st_no_buf, st_tx_ok, st_tx_done, st_trunc, busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  txring_fetch #(.AW(AW), .IDX_W(4), .FRAME_MAX(FMAX)) i_txring_fetch (
    .clk(clk), .rst(rst), .ctl_tx_en(ctl_tx_en), .ctl_dma_en(ctl_dma_en),
    .ctl_loop_en(ctl_loop_en), .poll_req(poll_req), .ring_base(ring_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_tdata(tx_tdata), .tx_tvalid(tx_tvalid), .tx_tlast(tx_tlast), .tx_tready(tx_tready),
    .lb_tdata(lb_tdata), .lb_tvalid(lb_tvalid), .lb_tlast(lb_tlast), .lb_tready(lb_tready),
    .st_no_buf(st_no_buf), .st_tx_ok(st_tx_ok), .st_tx_done(st_tx_done),
    .st_trunc(st_trunc), .busy(busy)
  );

  logic [31:0] mem [1024];
  logic [7:0]  got_q[$];
  logic        last_q[$];
  logic [7:0]  lb_q[$];
  logic [7:0]  exp_q[$];
  int checks = 0, failures = 0;
  int n_nobuf, n_ok, n_fin, n_trunc, n_req, n_lblast;
  int gap = 0, gap_lim = 0, rdy_cnt = 0;
  bit done_flag = 0;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 29 + 7) & 255);
  endfunction

  function automatic int buf_of(int slot);
    return BUF_BASE + slot * 64;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // memory model, stream sinks and status counters, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        if (gap < gap_lim) gap++;
        else begin
          gap = 0;
          gap_lim = (gap_lim + 1) % 3;
          if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
          else mem_rdata = mem[mem_addr[11:2]];
          mem_ack = 1'b1;
        end
      end else mem_ack = 1'b0;
      rdy_cnt++;
      tx_tready = (rdy_cnt % 3) != 1;
      lb_tready = (rdy_cnt % 4) != 0;
      if (tx_tvalid && tx_tready) begin got_q.push_back(tx_tdata); last_q.push_back(tx_tlast); end
      if (lb_tvalid && lb_tready) begin lb_q.push_back(lb_tdata); if (lb_tlast) n_lblast++; end
      if (st_no_buf) n_nobuf++;
      if (st_tx_ok) n_ok++;
      if (st_tx_done) n_fin++;
      if (st_trunc) n_trunc++;
      if (mem_req) n_req++;
    end
  end

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R13 watchdog act=hung exp=idle");
    summary();
  end

  task automatic clear_obs();
    got_q.delete(); last_q.delete(); lb_q.delete(); exp_q.delete();
    n_nobuf = 0; n_ok = 0; n_fin = 0; n_trunc = 0; n_req = 0; n_lblast = 0;
  endtask

  // flags: {eor, finreq, okreq, first, last} packed in bits 31:27
  task automatic put_desc(int slot, bit own, logic [4:0] flags, int len, logic [30:0] extra);
    mem[slot*4 + 0] = {own, extra};
    mem[slot*4 + 1] = {flags, 16'd0, 11'(len)};
    mem[slot*4 + 2] = 32'(buf_of(slot));
    mem[slot*4 + 3] = 32'd0;
  endtask

  task automatic expect_seg(int slot, int len, bit fresh);
    if (fresh) exp_q.delete();
    for (int k = 0; k < len; k++) exp_q.push_back(pat(buf_of(slot) + k));
  endtask

  task automatic poll();
    @(negedge clk); poll_req = 1'b1;
    @(negedge clk); poll_req = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    int t = 0;
    while (quiet < 3 && t < 20000) begin
      @(negedge clk); t++;
      if (busy) quiet = 0; else quiet++;
    end
    chk(t < 20000, "R13 walk end", t, 0);
  endtask

  task automatic cmp_frame(string tag, bit lb);
    if (lb) begin
      chk(lb_q.size() == exp_q.size(), tag, lb_q.size(), exp_q.size());
      for (int i = 0; i < lb_q.size() && i < exp_q.size(); i++)
        chk(lb_q[i] == exp_q[i], tag, lb_q[i], exp_q[i]);
    end else begin
      chk(got_q.size() == exp_q.size(), tag, got_q.size(), exp_q.size());
      for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
        chk(got_q[i] == exp_q[i], tag, got_q[i], exp_q[i]);
    end
  endtask

  initial begin
    int nl;
    for (int w = 0; w < 1024; w++) begin
      if (w < 256) mem[w] = 32'd0;
      else mem[w] = {pat(w*4+3), pat(w*4+2), pat(w*4+1), pat(w*4)};
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!mem_req, "R1 mem_req", mem_req, 0);
    chk(!tx_tvalid && !lb_tvalid, "R1 valid", tx_tvalid, 0);
    chk(!busy, "R1 busy", busy, 0);

    // R2 poll dropped while disabled
    clear_obs();
    ctl_tx_en = 1; ctl_dma_en = 0; poll();
    repeat (10) @(negedge clk);
    ctl_tx_en = 0; ctl_dma_en = 1; poll();
    repeat (10) @(negedge clk);
    ctl_tx_en = 1;
    repeat (10) @(negedge clk);
    chk(n_req == 0 && !busy, "R2 no start", n_req, 0);

    // single segment, slot 0: R3 R5 R7 R8 R4
    clear_obs();
    put_desc(0, 1, 5'b00111, 5, 31'h2AB);
    expect_seg(0, 5, 1);
    poll(); wait_idle();
    cmp_frame("R5 single", 0);
    chk(last_q.size() == 5 && last_q[4] && !last_q[3], "R5 tlast", last_q.size(), 5);
    chk(mem[0] == 32'h0000_02AB, "R7 writeback", mem[0], 32'h2AB);
    chk(n_ok == 1 && n_fin == 0, "R8 ok pulse", n_ok, 1);
    chk(n_nobuf == 1, "R4 stop", n_nobuf, 1);
    chk(mem[4] == 32'd0, "R4 no writeback", mem[4], 0);

    // three segments slots 1..3: R9 index kept, R13 walk continues, R12 throttled
    clear_obs();
    put_desc(1, 1, 5'b00010, 3, 31'h0);
    put_desc(2, 1, 5'b00000, 6, 31'h0);
    put_desc(3, 1, 5'b01001, 4, 31'h0);
    expect_seg(1, 3, 1); expect_seg(2, 6, 0); expect_seg(3, 4, 0);
    poll(); wait_idle();
    cmp_frame("R12 multi", 0);
    chk(!mem[4][31] && !mem[8][31] && !mem[12][31], "R13 all owned done", mem[8], 0);
    chk(n_fin == 1 && n_ok == 0, "R8 fin pulse", n_fin, 1);
    nl = 0; foreach (last_q[i]) if (last_q[i]) nl++;
    chk(nl == 1, "R5 one last", nl, 1);

    // end of ring wrap: slot 4 -> slot 0 -> slot 1 unowned
    clear_obs();
    put_desc(4, 1, 5'b10011, 2, 31'h0);
    put_desc(0, 1, 5'b00011, 7, 31'h0);
    expect_seg(4, 2, 1); expect_seg(0, 7, 0);
    poll(); wait_idle();
    cmp_frame("R9 wrap", 0);
    chk(last_q.size() == 9 && last_q[1] && last_q[8], "R9 two frames", last_q.size(), 9);
    chk(n_nobuf == 1 && !mem[0][31], "R9 stop at slot1", n_nobuf, 1);

    // loopback slot 1
    clear_obs();
    ctl_loop_en = 1;
    put_desc(1, 1, 5'b00011, 6, 31'h0);
    expect_seg(1, 6, 1);
    poll(); wait_idle();
    ctl_loop_en = 0;
    cmp_frame("R6 loop data", 1);
    chk(got_q.size() == 0, "R6 line idle", got_q.size(), 0);
    chk(n_lblast == 1, "R6 loop last", n_lblast, 1);

    // repeated first mark: slots 2,3
    clear_obs();
    put_desc(2, 1, 5'b00010, 4, 31'h0);
    put_desc(3, 1, 5'b00011, 3, 31'h0);
    expect_seg(3, 3, 1);
    poll(); wait_idle();
    cmp_frame("R5 first resets", 0);

    // truncation: slots 4,5 of 20 bytes each into 32-byte store
    clear_obs();
    put_desc(4, 1, 5'b00010, 20, 31'h0);
    put_desc(5, 1, 5'b00001, 20, 31'h0);
    expect_seg(4, 20, 1); expect_seg(5, 12, 0);
    poll(); wait_idle();
    cmp_frame("R10 trunc data", 0);
    chk(n_trunc == 1, "R10 trunc pulse", n_trunc, 1);

    // zero-length frame slot 6
    clear_obs();
    put_desc(6, 1, 5'b00111, 0, 31'h15);
    poll(); wait_idle();
    chk(got_q.size() == 0, "R14 no bytes", got_q.size(), 0);
    chk(mem[24] == 32'h15 && n_ok == 1, "R14 writeback", mem[24], 32'h15);
    chk(n_trunc == 0, "R10 no trunc", n_trunc, 0);

    // poll during walk: slot 7 with end of ring
    clear_obs();
    put_desc(7, 1, 5'b10011, 20, 31'h0);
    expect_seg(7, 20, 1);
    poll();
    repeat (6) @(negedge clk);
    chk(busy, "R11 busy mid walk", busy, 1);
    poll(); wait_idle();
    cmp_frame("R11 frame", 0);
    chk(n_nobuf == 2, "R11 second pass", n_nobuf, 2);

    // length sweep 1..12 on slots 0..11
    for (int L = 1; L <= 12; L++) begin
      clear_obs();
      put_desc(L - 1, 1, 5'b00011, L, 31'h0);
      expect_seg(L - 1, L, 1);
      poll(); wait_idle();
      cmp_frame("R3 sweep", 0);
      chk(last_q.size() == L && last_q[L-1], "R5 sweep last", last_q.size(), L);
    end

    summary();
  end

endmodule